// File: doc/BRIEF.md
# Multichannel Interrupt Vector and Command Unit

This block is the host-facing interrupt and command logic of an eight-channel serial concentrator. Each channel owns a one-byte command register that holds three interrupt enables (modem, receive, transmit) alongside two one-shot bits: a command-valid flag and a modem-request reset. Channel engines raise interrupt requests by strobing one of three request vectors. The unit latches every request and publishes one channel per interrupt class in a 16-byte vector region. The host reads that region to learn which channel needs service.

For each class, the vector region holds the channel number spread one bit per byte, least significant bit first. A pending byte follows the three number bytes. The host acknowledges a class by writing zero to bit 0 of its pending byte. This drops the published channel's request, and the next requester is then published. To issue a command, the host writes the channel's command register and then writes that channel's new-command register. The unit marks the command pending for one cycle, strobes it to the channel engine, carries out a modem-request reset if one is asked for, and clears the one-shot bits.

Each interrupt class runs a two-state machine. In VEC_IDLE, the transition "publish" to VEC_POSTED is taken when any enabled channel holds a request. The lowest such channel is captured at that point. In VEC_POSTED, the transition "acknowledge" back to VEC_IDLE is taken on a host write of 0 to the pending byte. Each channel also runs a command machine. In CMD_IDLE, the transition "issue" to CMD_PEND is taken on a new-command write. In CMD_PEND, the transition "consume" back to CMD_IDLE is taken on the next edge. If another new-command write arrives in that same cycle, the machine stays in CMD_PEND instead.

Top module: `irq_vector_cmd`

## Requirements
- R1: After reset, every vector byte, every command register and every new-command counter reads 0, and irq and cmd_busy are 0.
- R2: Classes sit at base 0 (modem), 4 (receive) and 8 (transmit). At base+0, base+1 and base+2, bit 0 is channel-number bit 0, 1 and 2 respectively, and base+3 bit 0 is the pending flag. Bits 7:1 of these bytes read 0.
- R3: When several channels hold a request of one class, the lowest-numbered channel whose enable for that class is 1 is published. A request whose enable is 0 stays latched but is not published until the enable is set.
- R4: Writing 0 to bit 0 of a class's pending byte clears that class's published request, and the channel bytes read 0 until the next channel is published. Writing 1 to a pending byte, or writing anything to a channel-number byte, has no effect.
- R5: Vector bytes 12 to 15 and addresses 0x20 to 0x3F read 0, and writes to them are ignored.
- R6: The command register of channel c is at 0x10+c. Bit 0 is reset modem request, bit 1 is modem enable, bit 2 is receive enable, bit 3 is transmit enable and bit 7 is command valid. Bits 6:4 read 0. Once a command is consumed, bits 0 and 7 read 0 and the enable bits are unchanged.
- R7: Any write to 0x18+c increments channel c's counter, which reads back at that address. It sets cmd_busy[c] and cmd_go[c] for exactly the following clock cycle, after which both return to 0.
- R8: Consuming a command with bits 7 and 0 both set clears channel c's latched modem request. Without bit 7, the request is kept.
- R9: irq is 1 exactly when at least one of the three pending flags is 1.
- R10: A read with host_rd high at an edge returns its byte on host_rdata with host_rd_vld high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 6 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| host_rd_vld | output | 1 | Read data valid |
| mdm_req | input | 8 | Modem interrupt request strobes, one per channel |
| rx_req | input | 8 | Receive interrupt request strobes |
| tx_req | input | 8 | Transmit interrupt request strobes |
| cmd_go | output | 8 | Command strobe to each channel engine |
| cmd_busy | output | 8 | Command pending; channel status not valid |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions assume the host never writes a new-command register in two consecutive cycles. Under that assumption, each cmd_busy bit lasts a single cycle. They also assume reads follow the registered one-cycle latency. The stimulus tasks meet these assumptions by leaving an idle cycle after every host write and read. They also hold request strobes for one cycle only and wait two cycles before sampling the vector region, so that latching and publishing have both completed.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int NUM_CLASS = 3;
    localparam int CLS_MDM   = 0;
    localparam int CLS_RX    = 1;
    localparam int CLS_TX    = 2;

    localparam int DW        = 8;
    localparam int CB_RSTMDM = 0;
    localparam int CB_EN_MDM = 1;
    localparam int CB_EN_RX  = 2;
    localparam int CB_EN_TX  = 3;
    localparam int CB_VALID  = 7;
    localparam logic [DW-1:0] CMD_MASK = 8'h8F;

    typedef enum logic {VEC_IDLE, VEC_POSTED} vec_state_e;
    typedef enum logic {CMD_IDLE, CMD_PEND}   cmd_state_e;
endpackage

// File: rtl/ivc_vec_class.sv
module ivc_vec_class
    import ivc_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_set,
    input  logic [NCH-1:0] ext_clr,
    input  logic [NCH-1:0] en,
    input  logic           pend_clr,
    output logic           posted,
    output logic [CHW-1:0] chan
);
    vec_state_e     st_q, st_d;
    logic [NCH-1:0] req_q, cand, drop;
    logic [CHW-1:0] pick;
    logic           any;

    // lowest-numbered enabled requester
    always_comb begin
        cand = req_q & en;
        any  = |cand;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) pick = CHW'(i);
        end
    end

    always_comb begin
        st_d = st_q;
        drop = '0;
        unique case (st_q)
            VEC_IDLE:   if (any) st_d = VEC_POSTED;
            VEC_POSTED: if (pend_clr) begin
                st_d       = VEC_IDLE;
                drop[chan] = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= VEC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            chan  <= '0;
        end else begin
            req_q <= (req_q & ~drop & ~ext_clr) | req_set;
            if (st_q == VEC_IDLE && any)
                chan <= pick;
            else if (st_q == VEC_POSTED && pend_clr)
                chan <= '0;
        end
    end

    assign posted = (st_q == VEC_POSTED);
endmodule

// File: rtl/ivc_chan_cmd.sv
module ivc_chan_cmd
    import ivc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          newcmd_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] cnt_q,
    output logic          busy,
    output logic          go,
    output logic          mdm_clr,
    output logic [NUM_CLASS-1:0] en
);
    cmd_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CMD_IDLE: if (newcmd_wr) st_d = CMD_PEND;
            CMD_PEND: st_d = newcmd_wr ? CMD_PEND : CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CMD_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            cnt_q <= '0;
        end else begin
            if (st_q == CMD_PEND) begin
                cmd_q[CB_RSTMDM] <= 1'b0;
                cmd_q[CB_VALID]  <= 1'b0;
            end
            if (cmd_wr)    cmd_q <= wdata & CMD_MASK;
            if (newcmd_wr) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy    = (st_q == CMD_PEND);
    assign go      = busy;
    assign mdm_clr = busy & cmd_q[CB_VALID] & cmd_q[CB_RSTMDM];
    assign en[CLS_MDM] = cmd_q[CB_EN_MDM];
    assign en[CLS_RX]  = cmd_q[CB_EN_RX];
    assign en[CLS_TX]  = cmd_q[CB_EN_TX];
endmodule

// File: rtl/irq_vector_cmd.sv
module irq_vector_cmd
    import ivc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  host_addr,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           host_rd_vld,
    input  logic [NCH-1:0] mdm_req,
    input  logic [NCH-1:0] rx_req,
    input  logic [NCH-1:0] tx_req,
    output logic [NCH-1:0] cmd_go,
    output logic [NCH-1:0] cmd_busy,
    output logic           irq
);
    localparam int CHW      = $clog2(NCH);
    localparam int STRIDE   = CHW + 1;
    localparam int CMD_BASE = 16;
    localparam int NEW_BASE = CMD_BASE + NCH;

    logic [DW-1:0]        cmd_reg [NCH];
    logic [DW-1:0]        cnt     [NCH];
    logic [NUM_CLASS-1:0] ch_en   [NCH];
    logic [NCH-1:0]       mdm_clr;
    logic [NCH-1:0]       en_cls  [NUM_CLASS];
    logic [NCH-1:0]       set_cls [NUM_CLASS];
    logic [NCH-1:0]       clr_cls [NUM_CLASS];
    logic [CHW-1:0]       vchan   [NUM_CLASS];
    logic [NUM_CLASS-1:0] vpost, pend_clr;
    logic [DW-1:0]        rd_mux;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ivc_chan_cmd u_cmd (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_wr    (host_wr && host_addr == AW'(CMD_BASE + ch)),
            .newcmd_wr (host_wr && host_addr == AW'(NEW_BASE + ch)),
            .wdata     (host_wdata),
            .cmd_q     (cmd_reg[ch]),
            .cnt_q     (cnt[ch]),
            .busy      (cmd_busy[ch]),
            .go        (cmd_go[ch]),
            .mdm_clr   (mdm_clr[ch]),
            .en        (ch_en[ch])
        );
    end

    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int ch = 0; ch < NCH; ch++) en_cls[c][ch] = ch_en[ch][c];
            pend_clr[c] = host_wr && !host_wdata[0]
                          && host_addr == AW'(c * STRIDE + CHW);
        end
        set_cls[CLS_MDM] = mdm_req;
        set_cls[CLS_RX]  = rx_req;
        set_cls[CLS_TX]  = tx_req;
        clr_cls[CLS_MDM] = mdm_clr;
        clr_cls[CLS_RX]  = '0;
        clr_cls[CLS_TX]  = '0;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        ivc_vec_class #(.NCH(NCH)) u_vec (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_set  (set_cls[c]),
            .ext_clr  (clr_cls[c]),
            .en       (en_cls[c]),
            .pend_clr (pend_clr[c]),
            .posted   (vpost[c]),
            .chan     (vchan[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int b = 0; b < CHW; b++) begin
                if (host_addr == AW'(c * STRIDE + b))
                    rd_mux = {{(DW-1){1'b0}}, vchan[c][b]};
            end
            if (host_addr == AW'(c * STRIDE + CHW))
                rd_mux = {{(DW-1){1'b0}}, vpost[c]};
        end
        for (int ch = 0; ch < NCH; ch++) begin
            if (host_addr == AW'(CMD_BASE + ch)) rd_mux = cmd_reg[ch];
            if (host_addr == AW'(NEW_BASE + ch)) rd_mux = cnt[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rd_vld <= 1'b0;
        end else begin
            host_rd_vld <= host_rd;
            if (host_rd) host_rdata <= rd_mux;
        end
    end

    assign irq = |vpost;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
    parameter int NCH = 8,
    parameter int AW  = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  host_addr,
    input logic           host_wr,
    input logic           host_rd,
    input logic [7:0]     host_rdata,
    input logic           host_rd_vld,
    input logic [NCH-1:0] cmd_busy
);
    localparam int NEW_BASE = 16 + NCH;

    // R10
    rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rd_vld);

    // R10
    no_rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rd_vld);

    // R5
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr >= AW'(12) && host_addr <= AW'(15)) |=> host_rdata == 8'h00);

    // R2
    vec_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr < AW'(16)) |=> host_rdata[7:1] == 7'd0);

    // R7
    busy_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr >= AW'(NEW_BASE) && host_addr < AW'(NEW_BASE + NCH))
        |=> $countones(cmd_busy) == 1);

    // R7
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy != '0) |=> (cmd_busy & $past(cmd_busy)) == '0);
endmodule

bind irq_vector_cmd ivc_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .host_rd_vld (host_rd_vld),
    .cmd_busy    (cmd_busy)
);

// File: tb/tb_irq_vector_cmd.sv
`timescale 1ns/1ps
module tb_irq_vector_cmd;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rd_vld;
    logic [7:0] mdm_req = '0, rx_req = '0, tx_req = '0;
    logic [7:0] cmd_go, cmd_busy;
    logic       irq;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [5:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t exp_q[$];

    always #2 clk = ~clk;

    irq_vector_cmd dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rd_vld(host_rd_vld), .mdm_req(mdm_req), .rx_req(rx_req),
        .tx_req(tx_req), .cmd_go(cmd_go), .cmd_busy(cmd_busy), .irq(irq)
    );

    // monitor: pops expected read results as the design returns them
    always @(negedge clk) begin
        if (rst_n && host_rd_vld) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected read data got=%h exp=none", host_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                if (host_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%h got=%h exp=%h", it.tag, it.addr, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        it.addr = a; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // class block at base: three channel-number bytes LSB first, then pending
    task automatic rd_cls(input logic [5:0] base, input int ch, input bit pend, input string tag);
        for (int b = 0; b < 3; b++) rd(base + 6'(b), {7'd0, 1'(ch >> b)}, tag);
        rd(base + 6'd3, {7'd0, pend}, tag);
    endtask

    task automatic pulse(input logic [7:0] m, input logic [7:0] r, input logic [7:0] t);
        @(negedge clk);
        mdm_req = m; rx_req = r; tx_req = t;
        @(negedge clk);
        mdm_req = '0; rx_req = '0; tx_req = '0;
        idle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        for (int a = 0; a < 32; a++) rd(6'(a), 8'h00, "R1");
        check({7'd0, irq}, 8'h00, "R1 irq");
        check(cmd_busy, 8'h00, "R1 busy");

        // enables: ch5 and ch2 all classes, ch6 modem only, ch3 none
        wr(6'h15, 8'h0E); wr(6'h12, 8'h0E); wr(6'h16, 8'h02);

        pulse(8'h00, 8'h08, 8'h00);
        rd_cls(6'd4, 0, 1'b0, "R3 disabled");
        check({7'd0, irq}, 8'h00, "R9 idle");

        pulse(8'h00, 8'h24, 8'h00);
        rd_cls(6'd4, 2, 1'b1, "R3 lowest");
        check({7'd0, irq}, 8'h01, "R9 rx");

        wr(6'h05, 8'h01); wr(6'h07, 8'h01); idle(2);
        rd_cls(6'd4, 2, 1'b1, "R4 ignored");

        wr(6'h07, 8'h00); idle(2);
        rd_cls(6'd4, 5, 1'b1, "R4 next");
        wr(6'h07, 8'h00); idle(2);
        rd_cls(6'd4, 0, 1'b0, "R4 empty");
        check({7'd0, irq}, 8'h00, "R9 cleared");

        wr(6'h13, 8'h04); idle(2);
        rd_cls(6'd4, 3, 1'b1, "R3 late enable");
        wr(6'h07, 8'h00); idle(2);

        pulse(8'h40, 8'h00, 8'h20);
        rd_cls(6'd0, 6, 1'b1, "R2 modem");
        rd_cls(6'd8, 5, 1'b1, "R2 tx");
        check({7'd0, irq}, 8'h01, "R9 two");
        wr(6'h0B, 8'h00); idle(2);
        rd_cls(6'd8, 0, 1'b0, "R2 tx clr");

        wr(6'h0C, 8'hFF); wr(6'h0F, 8'hFF);
        for (int a = 12; a < 16; a++) rd(6'(a), 8'h00, "R5");
        wr(6'h25, 8'hFF);
        rd(6'h25, 8'h00, "R5 high");

        wr(6'h11, 8'h70);
        rd(6'h11, 8'h00, "R6 reserved");

        // reset-modem command with valid, ch6 still posted
        pulse(8'h04, 8'h00, 8'h00);
        wr(6'h12, 8'h8F);
        rd(6'h12, 8'h8F, "R6 write");
        wr(6'h1A, 8'h00);
        check(cmd_busy, 8'h04, "R7 busy");
        check(cmd_go, 8'h04, "R7 go");
        idle(1);
        check(cmd_busy, 8'h00, "R7 busy end");
        check(cmd_go, 8'h00, "R7 go end");
        rd(6'h12, 8'h0E, "R6 oneshot");
        rd(6'h1A, 8'h01, "R7 count");
        wr(6'h03, 8'h00); idle(2);
        rd_cls(6'd0, 0, 1'b0, "R8 cleared");
        check({7'd0, irq}, 8'h00, "R9 none");

        // reset-modem without valid keeps the request
        wr(6'h12, 8'h0D);
        pulse(8'h04, 8'h00, 8'h00);
        wr(6'h1A, 8'h00); idle(2);
        rd_cls(6'd0, 0, 1'b0, "R3 modem off");
        wr(6'h12, 8'h0E); idle(2);
        rd_cls(6'd0, 2, 1'b1, "R8 kept");
        rd(6'h1A, 8'h02, "R7 count2");

        idle(4);
        check(8'(exp_q.size()), 8'h00, "R10 reads outstanding");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule